// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the command side of a parallel NOR flash that sits on a processor bus. Behind it is a small on-chip byte array. Bus writes carry a byte address, a size code and up to 32 bits of data. A write does not go straight into the array. In the idle phase the low data byte is taken as a command. The commands select what reads return: array contents, the status byte, or a fixed identification table. One command opens a buffered program sequence.

The buffered program sequence has four steps:
1. An opening command.
2. One write that gives the number of data writes minus one.
3. That many data writes.
4. A closing confirm byte.

Data writes can only clear bits in the array, as real flash programming does. Any command or step the block does not support drops it back to plain array reads. A build parameter chooses the byte order used when a multi-byte value is spread over consecutive addresses.

Top module: `nor_cmd_fsm`

## Requirements
- R1: After reset, reads return array data, every array byte reads 0xFF, the sequence is idle and the status byte is 0x00.
- R2: In the idle phase, low data byte 0x70 makes later reads return the status byte in rdata[7:0], with ready at bit 7 and all other bits zero. Low data byte 0xFF makes later reads return array data again.
- R3: In the idle phase, low data byte 0x98 makes later reads return one identification byte in rdata[7:0], indexed by addr[7:0]. Offsets 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59. Offsets 0x13 and 0x14 hold 0x01 and 0x00.
- R4: The identification table also describes the geometry. Offset 0x27 holds log2 of the total byte count and 0x2A holds 0x04, the widest write in bytes. Offset 0x2C holds 0x01 for one uniform region. Offsets 0x2D and 0x2E hold the block count minus one, low byte first. Offsets 0x2F and 0x30 hold the block size divided by 256, low byte first. Every other offset reads 0x00.
- R5: In the idle phase, low data byte 0xE8 opens a buffered program sequence. The next write supplies a count N in its low data bits. Exactly N+1 data writes follow, and then the sequence waits for a confirm write.
- R6: A data write stores 1, 2 or 4 bytes at addr, addr+1 and so on, for size code 0, 1, and 2 or 3. With BIG_ENDIAN=0 the least significant byte goes to the lowest address. With BIG_ENDIAN=1 the most significant byte of the stored width goes there. Array reads assemble the four bytes from addr to addr+3 by the same rule.
- R7: A data write replaces each stored byte with the bitwise AND of that byte and the new byte, so it never sets a bit.
- R8: Opening a sequence and each data write set the ready bit (status bit 7). From the opening command until the sequence ends, reads return the status byte.
- R9: A confirm write with low data byte 0xD0 ends the sequence in the idle phase with ready set. Reads keep returning status until a 0xFF command.
- R10: A confirm write with any other low byte aborts to array reads in the idle phase. Bytes written before the abort are kept, and the next write is decoded as a command.
- R11: Any other idle-phase low data byte selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe; rdata updates at the same edge |
| addr | input | ADDR_W | Byte address |
| size | input | 2 | Write width code: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes |
| wdata | input | 32 | Write data; the low byte carries commands |
| rdata | output | 32 | Registered read data |

## Verification
Most wrong internal states become visible at the read port on the next read. A sequence phase that is off by one turns status reads into array reads, or the reverse. A count that is off by one shows up in two ways: the confirm byte gets consumed as data, or the last data write is taken as a bad confirm and causes an abort. Both cases are visible at the first read after confirm. Byte-order and AND faults only appear on array reads after the sequence has ended. The bench therefore reads back at unaligned offsets, where the two byte orders give different words.

// File: rtl/nor_pkg.sv
package nor_pkg;

  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_BLOCK   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  typedef enum logic [1:0] {PH_IDLE, PH_COUNT, PH_DATA, PH_CONFIRM} phase_e;
  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_QUERY} rsrc_e;

  // bytes carried by a write of the given size code
  function automatic int unsigned size_bytes(logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // byte landing at offset k of an n-byte write
  function automatic logic [7:0] lane_byte(logic [31:0] d, int unsigned n,
                                           int unsigned k, logic big);
    int unsigned sh;
    sh = big ? 8 * (n - 1 - k) : 8 * k;
    return 8'(d >> sh);
  endfunction

  // trailing zero count of a power-of-two length
  function automatic logic [7:0] tz_count(longint unsigned n);
    logic [7:0] r;
    logic       seen;
    r = 8'd0;
    seen = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (!seen && n[i]) begin
        r = 8'(i);
        seen = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] ident_byte(logic [7:0] off, longint unsigned total,
                                            longint unsigned blk, longint unsigned nblk);
    case (off)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h27:   return tz_count(total);
      8'h2A:   return 8'h04;
      8'h2C:   return 8'h01;
      8'h2D:   return 8'(nblk - 1);
      8'h2E:   return 8'((nblk - 1) >> 8);
      8'h2F:   return 8'(blk >> 8);
      8'h30:   return 8'(blk >> 16);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nor_seq.sv
module nor_seq
  import nor_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       cmd_byte,
  input  logic [CNT_W-1:0] cnt_in,
  output phase_e           phase,
  output logic [7:0]       cmd,
  output logic [CNT_W-1:0] cnt,
  output logic             ready,
  output logic             data_wr,
  output logic             confirm_ok,
  output logic             abort,
  output rsrc_e            rd_src
);

  logic known_cmd;

  always_comb begin
    known_cmd = (cmd_byte == CMD_READ) || (cmd_byte == CMD_STATUS) ||
                (cmd_byte == CMD_QUERY) || (cmd_byte == CMD_BLOCK);
    data_wr    = wr_en && (phase == PH_DATA);
    confirm_ok = wr_en && (phase == PH_CONFIRM) && (cmd_byte == CMD_CONFIRM);
    abort      = wr_en && (((phase == PH_IDLE) && !known_cmd) ||
                           ((phase == PH_CONFIRM) && (cmd_byte != CMD_CONFIRM)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cmd   <= 8'h00;
      cnt   <= '0;
      ready <= 1'b0;
    end else if (wr_en) begin
      case (phase)
        PH_IDLE: begin
          case (cmd_byte)
            CMD_STATUS: cmd <= CMD_STATUS;
            CMD_QUERY:  cmd <= CMD_QUERY;
            CMD_BLOCK: begin
              cmd   <= CMD_BLOCK;
              phase <= PH_COUNT;
              ready <= 1'b1;
            end
            default:    cmd <= 8'h00;
          endcase
        end
        PH_COUNT: begin
          cnt   <= cnt_in;
          phase <= PH_DATA;
        end
        PH_DATA: begin
          ready <= 1'b1;
          if (cnt == '0) phase <= PH_CONFIRM;
          else           cnt   <= cnt - 1'b1;
        end
        default: begin
          phase <= PH_IDLE;
          if (cmd_byte == CMD_CONFIRM) ready <= 1'b1;
          else                         cmd   <= 8'h00;
        end
      endcase
    end
  end

  always_comb begin
    if (phase != PH_IDLE)                              rd_src = SRC_STATUS;
    else if (cmd == CMD_STATUS || cmd == CMD_BLOCK)    rd_src = SRC_STATUS;
    else if (cmd == CMD_QUERY)                         rd_src = SRC_QUERY;
    else                                               rd_src = SRC_ARRAY;
  end

endmodule

// File: rtl/nor_array.sv
module nor_array
  import nor_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_en) begin
      for (int k = 0; k < 4; k++) begin
        if (k < size_bytes(size))
          mem[addr + ADDR_W'(k)] <= mem[addr + ADDR_W'(k)] &
                                    lane_byte(wdata, size_bytes(size), k, BIG_ENDIAN);
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 4; k++) begin
      if (BIG_ENDIAN) rd_word[8*(3-k) +: 8] = mem[addr + ADDR_W'(k)];
      else            rd_word[8*k +: 8]     = mem[addr + ADDR_W'(k)];
    end
  end

endmodule

// File: rtl/nor_ident.sv
module nor_ident
  import nor_pkg::*;
#(
  parameter longint unsigned TOTAL_BYTES = 1024,
  parameter longint unsigned BLOCK_BYTES = 512,
  parameter longint unsigned BLOCK_COUNT = 2
) (
  input  logic [7:0] off,
  output logic [7:0] qbyte
);

  always_comb qbyte = ident_byte(off, TOTAL_BYTES, BLOCK_BYTES, BLOCK_COUNT);

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BLOCK_BYTES = 512,
  parameter int BLOCK_COUNT = 2,
  parameter int CNT_W       = 8,
  parameter bit BIG_ENDIAN  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam longint unsigned TOTAL_BYTES = longint'(BLOCK_BYTES) * longint'(BLOCK_COUNT);

  phase_e           phase;
  logic [7:0]       cmd;
  logic [CNT_W-1:0] cnt;
  logic             ready;
  logic             data_wr;
  logic             confirm_ok;
  logic             abort;
  rsrc_e            rd_src;
  logic [31:0]      rd_word;
  logic [7:0]       qbyte;

  nor_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .cmd_byte   (wdata[7:0]),
    .cnt_in     (wdata[CNT_W-1:0]),
    .phase      (phase),
    .cmd        (cmd),
    .cnt        (cnt),
    .ready      (ready),
    .data_wr    (data_wr),
    .confirm_ok (confirm_ok),
    .abort      (abort),
    .rd_src     (rd_src)
  );

  nor_array #(.ADDR_W(ADDR_W), .BIG_ENDIAN(BIG_ENDIAN)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_en (data_wr),
    .addr    (addr),
    .size    (size),
    .wdata   (wdata),
    .rd_word (rd_word)
  );

  nor_ident #(
    .TOTAL_BYTES (TOTAL_BYTES),
    .BLOCK_BYTES (longint'(BLOCK_BYTES)),
    .BLOCK_COUNT (longint'(BLOCK_COUNT))
  ) u_ident (
    .off   (addr[7:0]),
    .qbyte (qbyte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (rd_src)
        SRC_STATUS: rdata <= {24'h0, ready, 7'h0};
        SRC_QUERY:  rdata <= {24'h0, qbyte};
        default:    rdata <= rd_word;
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_fsm_chk.sv
module nor_cmd_fsm_chk
  import nor_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       cmd_byte,
  input logic [CNT_W-1:0] cnt_in,
  input phase_e           phase,
  input logic [7:0]       cmd,
  input logic [CNT_W-1:0] cnt,
  input logic             ready,
  input logic             data_wr,
  input logic             confirm_ok,
  input logic             abort
);

  p_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && phase == PH_IDLE && cmd_byte == CMD_BLOCK) |=> (phase == PH_COUNT && ready));

  p_count_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && phase == PH_COUNT) |=> (phase == PH_DATA && cnt == $past(cnt_in)));

  p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cnt != '0) |=> (phase == PH_DATA && cnt == $past(cnt) - 1'b1));

  p_last_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cnt == '0) |=> (phase == PH_CONFIRM));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ready);

  p_confirm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_ok |=> (phase == PH_IDLE && ready && cmd == CMD_BLOCK));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (phase == PH_IDLE && cmd == 8'h00));

endmodule

bind nor_cmd_fsm nor_cmd_fsm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .cmd_byte   (wdata[7:0]),
  .cnt_in     (wdata[CNT_W-1:0]),
  .phase      (phase),
  .cmd        (cmd),
  .cnt        (cnt),
  .ready      (ready),
  .data_wr    (data_wr),
  .confirm_ok (confirm_ok),
  .abort      (abort)
);

// File: tb/nor_cmd_fsm_tb.sv
module nor_cmd_fsm_tb;

  localparam int ADDR_W = 10;

  typedef struct packed {
    logic        rd;
    logic [9:0]  addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] exp_le;
    logic [31:0] exp_be;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t VEC [NV] = '{
    {1'b1, 10'h000, 2'd0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'd1},  // R1 erased array
    {1'b0, 10'h000, 2'd0, 32'h70, 32'h0, 32'h0, 4'd2},               // R2 status mode
    {1'b1, 10'h000, 2'd0, 32'h0, 32'h00000000, 32'h00000000, 4'd1},  // R1 status clear
    {1'b0, 10'h000, 2'd0, 32'hFF, 32'h0, 32'h0, 4'd2},
    {1'b1, 10'h000, 2'd0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'd2},  // R2 back to array
    {1'b0, 10'h000, 2'd0, 32'h98, 32'h0, 32'h0, 4'd3},               // R3 ident mode
    {1'b1, 10'h010, 2'd0, 32'h0, 32'h51, 32'h51, 4'd3},
    {1'b1, 10'h011, 2'd0, 32'h0, 32'h52, 32'h52, 4'd3},
    {1'b1, 10'h012, 2'd0, 32'h0, 32'h59, 32'h59, 4'd3},
    {1'b1, 10'h013, 2'd0, 32'h0, 32'h01, 32'h01, 4'd3},
    {1'b1, 10'h014, 2'd0, 32'h0, 32'h00, 32'h00, 4'd3},
    {1'b1, 10'h027, 2'd0, 32'h0, 32'h0A, 32'h0A, 4'd4},              // R4 log2(1024)
    {1'b1, 10'h02A, 2'd0, 32'h0, 32'h04, 32'h04, 4'd4},
    {1'b1, 10'h02C, 2'd0, 32'h0, 32'h01, 32'h01, 4'd4},
    {1'b1, 10'h02D, 2'd0, 32'h0, 32'h01, 32'h01, 4'd4},
    {1'b1, 10'h02E, 2'd0, 32'h0, 32'h00, 32'h00, 4'd4},
    {1'b1, 10'h02F, 2'd0, 32'h0, 32'h02, 32'h02, 4'd4},
    {1'b1, 10'h030, 2'd0, 32'h0, 32'h00, 32'h00, 4'd4},
    {1'b0, 10'h000, 2'd0, 32'hFF, 32'h0, 32'h0, 4'd2},
    {1'b0, 10'h040, 2'd0, 32'hE8, 32'h0, 32'h0, 4'd5},               // R5 open
    {1'b1, 10'h040, 2'd0, 32'h0, 32'h80, 32'h80, 4'd8},              // R8 status during
    {1'b0, 10'h040, 2'd0, 32'h02, 32'h0, 32'h0, 4'd5},               // R5 count 2
    {1'b0, 10'h040, 2'd2, 32'h12345678, 32'h0, 32'h0, 4'd6},
    {1'b1, 10'h040, 2'd0, 32'h0, 32'h80, 32'h80, 4'd8},
    {1'b0, 10'h044, 2'd1, 32'h0000ABCD, 32'h0, 32'h0, 4'd6},
    {1'b0, 10'h046, 2'd0, 32'h0000005A, 32'h0, 32'h0, 4'd6},
    {1'b1, 10'h040, 2'd0, 32'h0, 32'h80, 32'h80, 4'd8},              // R8 awaiting confirm
    {1'b0, 10'h040, 2'd0, 32'hD0, 32'h0, 32'h0, 4'd9},
    {1'b1, 10'h040, 2'd0, 32'h0, 32'h80, 32'h80, 4'd9},              // R9 status kept
    {1'b0, 10'h000, 2'd0, 32'hFF, 32'h0, 32'h0, 4'd9},
    {1'b1, 10'h040, 2'd0, 32'h0, 32'h12345678, 32'h12345678, 4'd6},  // R6 round trip
    {1'b1, 10'h041, 2'd0, 32'h0, 32'hCD123456, 32'h345678AB, 4'd6},  // R6 byte order
    {1'b1, 10'h044, 2'd0, 32'h0, 32'hFF5AABCD, 32'hABCD5AFF, 4'd6},
    {1'b0, 10'h040, 2'd0, 32'hE8, 32'h0, 32'h0, 4'd7},
    {1'b0, 10'h040, 2'd0, 32'h00, 32'h0, 32'h0, 4'd7},
    {1'b0, 10'h040, 2'd0, 32'h0F, 32'h0, 32'h0, 4'd7},
    {1'b0, 10'h040, 2'd0, 32'hD0, 32'h0, 32'h0, 4'd7},
    {1'b0, 10'h040, 2'd0, 32'hFF, 32'h0, 32'h0, 4'd7},
    {1'b1, 10'h040, 2'd0, 32'h0, 32'h12345608, 32'h02345678, 4'd7},  // R7 AND program
    {1'b0, 10'h080, 2'd0, 32'hE8, 32'h0, 32'h0, 4'd10},
    {1'b0, 10'h080, 2'd0, 32'h00, 32'h0, 32'h0, 4'd10},
    {1'b0, 10'h080, 2'd0, 32'h00, 32'h0, 32'h0, 4'd10},
    {1'b0, 10'h080, 2'd0, 32'h55, 32'h0, 32'h0, 4'd10},              // R10 bad confirm
    {1'b1, 10'h080, 2'd0, 32'h0, 32'hFFFFFF00, 32'h00FFFFFF, 4'd10},
    {1'b0, 10'h000, 2'd0, 32'h70, 32'h0, 32'h0, 4'd10},
    {1'b1, 10'h000, 2'd0, 32'h0, 32'h80, 32'h80, 4'd10},             // R10 decoded as cmd
    {1'b0, 10'h000, 2'd0, 32'h20, 32'h0, 32'h0, 4'd11},              // R11 unknown
    {1'b1, 10'h040, 2'd0, 32'h0, 32'h12345608, 32'h02345678, 4'd11},
    {1'b0, 10'h0C0, 2'd0, 32'hE8, 32'h0, 32'h0, 4'd6},
    {1'b0, 10'h0C0, 2'd0, 32'h00, 32'h0, 32'h0, 4'd6},
    {1'b0, 10'h0C0, 2'd3, 32'hAABBCCDD, 32'h0, 32'h0, 4'd6},         // R6 size code 3
    {1'b0, 10'h0C0, 2'd0, 32'hD0, 32'h0, 32'h0, 4'd6},
    {1'b0, 10'h000, 2'd0, 32'hFF, 32'h0, 32'h0, 4'd6}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0]        size = 2'd0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata_le;
  logic [31:0]       rdata_be;
  int                n_run = 0;
  int                n_fail = 0;

  always #10 clk = ~clk;

  nor_cmd_fsm #(.ADDR_W(ADDR_W), .BIG_ENDIAN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .size(size), .wdata(wdata), .rdata(rdata_le)
  );

  nor_cmd_fsm #(.ADDR_W(ADDR_W), .BIG_ENDIAN(1'b1)) u_dut_be (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .size(size), .wdata(wdata), .rdata(rdata_be)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input int req, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a, input logic [31:0] ele,
                         input logic [31:0] ebe, input int req);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata_le, ele, req, "little-endian");
    check(rdata_be, ebe, req, "big-endian");
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: rdata cleared by reset
    check(rdata_le, 32'h0, 1, "rdata after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) do_read(VEC[i].addr, VEC[i].exp_le, VEC[i].exp_be, int'(VEC[i].req));
      else           do_write(VEC[i].addr, VEC[i].sz, VEC[i].wd);
    end
    // R6: size code 3 stored four bytes
    do_read(10'h0C0, 32'hAABBCCDD, 32'hAABBCCDD, 6);

    // R1: reset in mid-sequence restores erased array and array reads
    do_write(10'h100, 2'd0, 32'hE8);
    do_write(10'h100, 2'd0, 32'h03);
    do_write(10'h100, 2'd0, 32'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read(10'h0C0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1);
    do_read(10'h100, 32'hFFFFFFFF, 32'hFFFFFFFF, 1);

    // R5: count 1 means two data writes; the third write is the confirm
    do_write(10'h200, 2'd0, 32'hE8);
    do_write(10'h200, 2'd0, 32'h01);
    do_write(10'h200, 2'd0, 32'h11);
    do_write(10'h201, 2'd0, 32'h22);
    do_write(10'h000, 2'd0, 32'hD0);
    do_read(10'h200, 32'h80, 32'h80, 5);
    do_write(10'h000, 2'd0, 32'hFF);
    do_read(10'h200, 32'hFFFF2211, 32'h1122FFFF, 5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule